// File: doc/BRIEF.md
# Byte-Wide NOR Flash Command Sequencer

This block is a synthesizable model of a byte-wide parallel NOR flash that is controlled by unlock-gated command sequences. It sits on a simple synchronous bus with an address, write data, a write strobe and a read strobe. It holds a small internal byte array that is split into equal sectors. Each write strobe is one bus cycle of a command sequence. A write-cycle state machine checks every cycle against the unlock keys and addresses it expects. A cycle that does not match returns the block to plain read mode.

The block decodes several operations: byte program, where the written data can only clear bits; sector erase and chip erase; an autoselect mode for reading identification bytes; a query mode that returns a table of device geometry; and an unlock bypass mode, in which a sequence skips the first unlock pair. Erase timing comes from a companion block. The sequencer raises `busy` when an erase starts and stays there until the companion pulses `op_done`.

Top module: `nor_cmd_flash`

## Requirements
- R1: In read mode, a sequence starts with 0xAA written to offset UNLOCK0 (default 0x55), followed by 0x55 written to offset UNLOCK1 (default 0xAA). The offset is addr[7:0]. Any cycle that breaks the pair returns to read mode.
- R2: The third cycle is the command cycle. It must address UNLOCK0 unless bypass is active. The values 0x80 (erase setup), 0x90 (autoselect), 0xA0 (program) and 0x20 (enter bypass) are accepted. Any other value, or a wrong offset, returns to read mode.
- R3: After 0x80 and a second unlock pair, 0x10 written at UNLOCK0 erases the whole array to 0xFF. 0x30 written at any address erases the sector that holds that address, which is addr[ADDR_W-1:SECT_LOG2]. 0x10 at any other offset returns to read mode without erasing. After an erase starts, `busy` reads 1 until an `op_done` pulse.
- R4: The write after 0xA0 stores the old byte AND the new data, so a program can only clear bits.
- R5: Writing 0xF0 returns to read mode from any state and clears bypass. The one exception is the program data cycle, which stores 0xF0 as data.
- R6: Writing 0x98 at offset 0x55 enters query mode. This works from read mode, from autoselect mode and at the first cycle of the second erase-setup unlock pair. Any write in query mode returns to read mode.
- R7: In autoselect mode, reads at offset 0x00 return MFR_ID (default 0x01), at 0x01 return DEV_ID (0x4F), at 0x02 return 0x00, at 0x0E return EXT_ID0 (0x22) and at 0x0F return EXT_ID1 (0x33). All other offsets return array data.
- R8: 0x20 at the command cycle enters bypass. In bypass, command cycles are accepted at any address. A program returns to the command cycle with bypass kept, and so does the end of an erase. Writing 0x90 and then 0x00 leaves bypass.
- R9: While `busy` is 1, writes other than 0xF0 change neither the array nor the sequence state.
- R10: In query mode, a read at offset i returns the table byte. The table holds 0x51, 0x52, 0x59 at 0x10..0x12 and 0x02 at 0x13. 0x27 holds log2 of the array size in bytes. 0x2C holds 0x01. 0x2D/0x2E hold the sector count minus one. 0x2F/0x30 hold the sector size divided by 256. Offsets of CFI_LEN (default 64) and above read 0x00.
- R11: `rdata` is registered. It is loaded on the clock edge that samples `rd_en` and holds its value otherwise. Reset clears `rdata` to 0x00 and `busy` to 0, sets the array to 0xFF and restarts any sequence in progress.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr | input | ADDR_W | Byte address for reads and writes |
| wdata | input | 8 | Write data or command byte |
| wr_en | input | 1 | Write strobe, one bus cycle per high clock |
| rd_en | input | 1 | Read strobe |
| op_done | input | 1 | Completion pulse from the timing companion |
| rdata | output | 8 | Registered read data |
| busy | output | 1 | An erase is in progress |

## Verification
Every write acts on the clock edge that samples `wr_en`. A state or array change can therefore be seen by a read issued in the very next cycle. `busy` is a state decode and is valid at the first sample point after the edge that accepts an erase command. `rdata` arrives one edge after `rd_en`. The bench drives all strobes for exactly one cycle from the falling edge and samples `rdata` and `busy` at the falling edge that follows the accepting rising edge. Each result is therefore read in its first valid cycle and never read before it is due.

// File: rtl/nor_pkg.sv
package nor_pkg;

  typedef enum logic [2:0] {
    WC_IDLE = 3'd0,
    WC_KEY2 = 3'd1,
    WC_OPC  = 3'd2,
    WC_PH3  = 3'd3,
    WC_PH4  = 3'd4,
    WC_PH5  = 3'd5,
    WC_BUSY = 3'd6,
    WC_QRY  = 3'd7
  } wc_e;

  localparam logic [7:0] KEY_A        = 8'hAA;
  localparam logic [7:0] KEY_B        = 8'h55;
  localparam logic [7:0] OP_ERASE_SET = 8'h80;
  localparam logic [7:0] OP_AUTOSEL   = 8'h90;
  localparam logic [7:0] OP_PROG      = 8'hA0;
  localparam logic [7:0] OP_BYPASS    = 8'h20;
  localparam logic [7:0] OP_CHIP      = 8'h10;
  localparam logic [7:0] OP_SECT      = 8'h30;
  localparam logic [7:0] OP_RESET     = 8'hF0;
  localparam logic [7:0] OP_QUERY     = 8'h98;
  localparam logic [7:0] QRY_OFF      = 8'h55;

  // geometry query table, derived from the array shape
  function automatic logic [7:0] cfi_byte(input logic [7:0] idx,
                                          input int sect_log2,
                                          input int sect_cnt,
                                          input int chip_log2,
                                          input int tbl_len);
    int cnt_m1;
    int sect_div;
    logic [7:0] v;
    cnt_m1   = sect_cnt - 1;
    sect_div = (1 << sect_log2) >> 8;
    v = 8'h00;
    if (int'(idx) < tbl_len) begin
      case (idx)
        8'h10: v = 8'h51;
        8'h11: v = 8'h52;
        8'h12: v = 8'h59;
        8'h13: v = 8'h02;
        8'h15: v = 8'h31;
        8'h27: v = 8'(chip_log2);
        8'h2C: v = 8'h01;
        8'h2D: v = 8'(cnt_m1 & 255);
        8'h2E: v = 8'((cnt_m1 >> 8) & 255);
        8'h2F: v = 8'(sect_div & 255);
        8'h30: v = 8'((sect_div >> 8) & 255);
        8'h31: v = 8'h50;
        8'h32: v = 8'h52;
        8'h33: v = 8'h49;
        8'h34: v = 8'h31;
        8'h35: v = 8'h30;
        default: v = 8'h00;
      endcase
    end
    return v;
  endfunction

endpackage

// File: rtl/nor_seq_fsm.sv
module nor_seq_fsm
  import nor_pkg::*;
#(
  parameter logic [7:0] UNLOCK0 = 8'h55,
  parameter logic [7:0] UNLOCK1 = 8'hAA
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_en,
  input  logic [7:0] off,
  input  logic [7:0] wdata,
  input  logic       op_done,
  output logic       prog_ev,
  output logic       chip_ev,
  output logic       sect_ev,
  output logic       busy,
  output logic       mode_id,
  output logic       mode_cfi
);

  wc_e        st_q, st_n;
  logic [7:0] cmd_q, cmd_n;
  logic       byp_q, byp_n;
  logic       seq_rst;

  logic key_a_hit, key_b_hit, qry_hit, prog_wait, abort_ev;

  assign key_a_hit = (off == UNLOCK0) && (wdata == KEY_A);
  assign key_b_hit = (off == UNLOCK1) && (wdata == KEY_B);
  assign qry_hit   = (off == QRY_OFF) && (wdata == OP_QUERY);
  assign prog_wait = (st_q == WC_PH3) && (cmd_q == OP_PROG);
  assign abort_ev  = wr_en && (wdata == OP_RESET) && !prog_wait;

  always_comb begin
    st_n    = st_q;
    cmd_n   = cmd_q;
    byp_n   = byp_q;
    seq_rst = 1'b0;
    prog_ev = 1'b0;
    chip_ev = 1'b0;
    sect_ev = 1'b0;
    if (abort_ev) begin
      seq_rst = 1'b1;
    end else if (st_q == WC_BUSY) begin
      if (op_done) begin
        st_n  = byp_q ? WC_OPC : WC_IDLE;
        cmd_n = 8'h00;
      end
    end else if (wr_en) begin
      case (st_q)
        WC_IDLE: begin
          if (qry_hit) begin
            st_n  = WC_QRY;
            cmd_n = OP_QUERY;
          end else if (key_a_hit) begin
            st_n = WC_KEY2;
          end else begin
            seq_rst = 1'b1;
          end
        end
        WC_KEY2: begin
          if (key_b_hit) st_n = WC_OPC;
          else           seq_rst = 1'b1;
        end
        WC_OPC: begin
          if (!byp_q && off != UNLOCK0) begin
            seq_rst = 1'b1;
          end else begin
            case (wdata)
              OP_BYPASS: begin
                byp_n = 1'b1;
                st_n  = WC_OPC;
                cmd_n = 8'h00;
              end
              OP_ERASE_SET, OP_AUTOSEL, OP_PROG: begin
                cmd_n = wdata;
                st_n  = WC_PH3;
              end
              default: seq_rst = 1'b1;
            endcase
          end
        end
        WC_PH3: begin
          case (cmd_q)
            OP_ERASE_SET: begin
              if (qry_hit) begin
                st_n  = WC_QRY;
                cmd_n = OP_QUERY;
              end else if (key_a_hit) begin
                st_n = WC_PH4;
              end else begin
                seq_rst = 1'b1;
              end
            end
            OP_PROG: begin
              prog_ev = 1'b1;
              if (byp_q) begin
                st_n  = WC_OPC;
                cmd_n = 8'h00;
              end else begin
                seq_rst = 1'b1;
              end
            end
            OP_AUTOSEL: begin
              if (byp_q && wdata == 8'h00) begin
                seq_rst = 1'b1;
              end else if (qry_hit) begin
                st_n  = WC_QRY;
                cmd_n = OP_QUERY;
              end else begin
                seq_rst = 1'b1;
              end
            end
            default: seq_rst = 1'b1;
          endcase
        end
        WC_PH4: begin
          if (key_b_hit) st_n = WC_PH5;
          else           seq_rst = 1'b1;
        end
        WC_PH5: begin
          if (wdata == OP_CHIP && off == UNLOCK0) begin
            chip_ev = 1'b1;
            st_n    = WC_BUSY;
            cmd_n   = OP_CHIP;
          end else if (wdata == OP_SECT) begin
            sect_ev = 1'b1;
            st_n    = WC_BUSY;
            cmd_n   = OP_SECT;
          end else begin
            seq_rst = 1'b1;
          end
        end
        default: seq_rst = 1'b1;
      endcase
    end
    if (seq_rst) begin
      st_n  = WC_IDLE;
      cmd_n = 8'h00;
      byp_n = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= WC_IDLE;
      cmd_q <= 8'h00;
      byp_q <= 1'b0;
    end else begin
      st_q  <= st_n;
      cmd_q <= cmd_n;
      byp_q <= byp_n;
    end
  end

  assign busy     = (st_q == WC_BUSY);
  assign mode_id  = (st_q == WC_PH3) && (cmd_q == OP_AUTOSEL);
  assign mode_cfi = (st_q == WC_QRY);

  // R5
  f0_reset_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wdata == OP_RESET && !prog_wait) |=> (st_q == WC_IDLE && !byp_q));

  // R9
  busy_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (!prog_ev && !chip_ev && !sect_ev));

  // R6
  qry_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_cfi && wr_en) |=> (st_q == WC_IDLE));

  // R3
  erase_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (chip_ev || sect_ev) |=> busy);

  // R8
  bypass_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (prog_ev && byp_q) |=> (st_q == WC_OPC && byp_q));

endmodule

// File: rtl/nor_array.sv
module nor_array #(
  parameter int SECT_LOG2 = 8,
  parameter int SECT_CNT  = 4,
  localparam int SEL_W    = $clog2(SECT_CNT),
  localparam int ADDR_W   = SECT_LOG2 + SEL_W,
  localparam int SECT_BYTES = 1 << SECT_LOG2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        wdata,
  input  logic              prog_ev,
  input  logic              chip_ev,
  input  logic              sect_ev,
  output logic [7:0]        rd_byte
);

  logic [7:0] sect_rd [SECT_CNT];

  for (genvar s = 0; s < SECT_CNT; s++) begin : g_sect
    logic [7:0] bank [SECT_BYTES];
    logic       hit;
    logic       wipe;
    assign hit  = (addr[ADDR_W-1:SECT_LOG2] == SEL_W'(s));
    assign wipe = chip_ev || (sect_ev && hit);

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        for (int i = 0; i < SECT_BYTES; i++) bank[i] <= 8'hFF;
      end else if (wipe) begin
        for (int i = 0; i < SECT_BYTES; i++) bank[i] <= 8'hFF;
      end else if (prog_ev && hit) begin
        bank[addr[SECT_LOG2-1:0]] <= bank[addr[SECT_LOG2-1:0]] & wdata;
      end
    end

    assign sect_rd[s] = bank[addr[SECT_LOG2-1:0]];
  end

  assign rd_byte = sect_rd[addr[ADDR_W-1:SECT_LOG2]];

  // R4
  evt_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({prog_ev, chip_ev, sect_ev}));

  // R4
  prog_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    prog_ev |=> ((rd_byte & ~$past(rd_byte)) == 8'h00) || $changed(addr));

endmodule

// File: rtl/nor_rd_mux.sv
module nor_rd_mux
  import nor_pkg::*;
#(
  parameter logic [7:0] MFR_ID  = 8'h01,
  parameter logic [7:0] DEV_ID  = 8'h4F,
  parameter logic [7:0] EXT_ID0 = 8'h22,
  parameter logic [7:0] EXT_ID1 = 8'h33,
  parameter int CFI_LEN   = 64,
  parameter int SECT_LOG2 = 8,
  parameter int SECT_CNT  = 4,
  localparam int CHIP_LOG2 = SECT_LOG2 + $clog2(SECT_CNT)
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       rd_en,
  input  logic [7:0] off,
  input  logic       mode_id,
  input  logic       mode_cfi,
  input  logic [7:0] arr_byte,
  output logic [7:0] rdata
);

  function automatic logic [7:0] id_byte(input logic [7:0] o, input logic [7:0] fall);
    case (o)
      8'h00:   return MFR_ID;
      8'h01:   return DEV_ID;
      8'h02:   return 8'h00;
      8'h0E:   return EXT_ID0;
      8'h0F:   return EXT_ID1;
      default: return fall;
    endcase
  endfunction

  logic [7:0] rd_sel;

  always_comb begin
    if (mode_cfi)     rd_sel = cfi_byte(off, SECT_LOG2, SECT_CNT, CHIP_LOG2, CFI_LEN);
    else if (mode_id) rd_sel = id_byte(off, arr_byte);
    else              rd_sel = arr_byte;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     rdata <= 8'h00;
    else if (rd_en) rdata <= rd_sel;
  end

  // R10
  cfi_tail_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && mode_cfi && int'(off) >= CFI_LEN) |=> (rdata == 8'h00));

  // R11
  rdata_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |=> $stable(rdata));

endmodule

// File: rtl/nor_cmd_flash.sv
module nor_cmd_flash #(
  parameter int SECT_LOG2 = 8,
  parameter int SECT_CNT  = 4,
  parameter logic [7:0] UNLOCK0 = 8'h55,
  parameter logic [7:0] UNLOCK1 = 8'hAA,
  parameter logic [7:0] MFR_ID  = 8'h01,
  parameter logic [7:0] DEV_ID  = 8'h4F,
  parameter logic [7:0] EXT_ID0 = 8'h22,
  parameter logic [7:0] EXT_ID1 = 8'h33,
  parameter int CFI_LEN   = 64,
  localparam int ADDR_W   = SECT_LOG2 + $clog2(SECT_CNT)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        wdata,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic              op_done,
  output logic [7:0]        rdata,
  output logic              busy
);

  logic       prog_ev, chip_ev, sect_ev;
  logic       mode_id, mode_cfi;
  logic [7:0] arr_byte;
  logic [7:0] off;

  assign off = addr[7:0];

  nor_seq_fsm #(
    .UNLOCK0 (UNLOCK0),
    .UNLOCK1 (UNLOCK1)
  ) u_fsm (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (wr_en),
    .off      (off),
    .wdata    (wdata),
    .op_done  (op_done),
    .prog_ev  (prog_ev),
    .chip_ev  (chip_ev),
    .sect_ev  (sect_ev),
    .busy     (busy),
    .mode_id  (mode_id),
    .mode_cfi (mode_cfi)
  );

  nor_array #(
    .SECT_LOG2 (SECT_LOG2),
    .SECT_CNT  (SECT_CNT)
  ) u_array (
    .clk     (clk),
    .rst_n   (rst_n),
    .addr    (addr),
    .wdata   (wdata),
    .prog_ev (prog_ev),
    .chip_ev (chip_ev),
    .sect_ev (sect_ev),
    .rd_byte (arr_byte)
  );

  nor_rd_mux #(
    .MFR_ID    (MFR_ID),
    .DEV_ID    (DEV_ID),
    .EXT_ID0   (EXT_ID0),
    .EXT_ID1   (EXT_ID1),
    .CFI_LEN   (CFI_LEN),
    .SECT_LOG2 (SECT_LOG2),
    .SECT_CNT  (SECT_CNT)
  ) u_mux (
    .clk      (clk),
    .rst_n    (rst_n),
    .rd_en    (rd_en),
    .off      (off),
    .mode_id  (mode_id),
    .mode_cfi (mode_cfi),
    .arr_byte (arr_byte),
    .rdata    (rdata)
  );

endmodule

// File: tb/nor_cmd_flash_bench.sv
`timescale 1ns/1ps
module nor_cmd_flash_bench;

  localparam int AW = 10;
  localparam logic [1:0] K_W = 2'd0, K_R = 2'd1, K_D = 2'd2, K_B = 2'd3;
  localparam int NV = 59;

  // {kind, requirement number, address, data or expected value}
  localparam logic [23:0] VEC [NV] = '{
    {K_W,4'd4,10'h055,8'hAA}, {K_W,4'd4,10'h0AA,8'h55}, {K_W,4'd4,10'h055,8'hA0},
    {K_W,4'd4,10'h010,8'h3C}, {K_R,4'd4,10'h010,8'h3C},                 // R4 first program
    {K_W,4'd4,10'h055,8'hAA}, {K_W,4'd4,10'h0AA,8'h55}, {K_W,4'd4,10'h055,8'hA0},
    {K_W,4'd4,10'h010,8'h0F}, {K_R,4'd4,10'h010,8'h0C},                 // R4 AND result
    {K_W,4'd1,10'h055,8'hAA}, {K_W,4'd1,10'h0AB,8'h55}, {K_W,4'd1,10'h055,8'hA0},
    {K_W,4'd1,10'h020,8'h00}, {K_R,4'd1,10'h020,8'hFF},                 // R1 broken pair
    {K_W,4'd5,10'h055,8'hAA}, {K_W,4'd5,10'h0AA,8'h55}, {K_W,4'd5,10'h000,8'hF0},
    {K_W,4'd5,10'h055,8'hA0}, {K_W,4'd5,10'h020,8'h00}, {K_R,4'd5,10'h020,8'hFF}, // R5 abort
    {K_W,4'd5,10'h055,8'hAA}, {K_W,4'd5,10'h0AA,8'h55}, {K_W,4'd5,10'h055,8'hA0},
    {K_W,4'd5,10'h031,8'hF0}, {K_R,4'd5,10'h031,8'hF0},                 // R5 data exception
    {K_W,4'd7,10'h055,8'hAA}, {K_W,4'd7,10'h0AA,8'h55}, {K_W,4'd7,10'h055,8'h90},
    {K_R,4'd7,10'h000,8'h01}, {K_R,4'd7,10'h001,8'h4F}, {K_R,4'd7,10'h002,8'h00},
    {K_R,4'd7,10'h00E,8'h22}, {K_R,4'd7,10'h00F,8'h33}, {K_R,4'd7,10'h010,8'h0C}, // R7
    {K_W,4'd6,10'h055,8'h98},                                           // R6 from autoselect
    {K_R,4'd10,10'h010,8'h51}, {K_R,4'd10,10'h012,8'h59}, {K_R,4'd10,10'h027,8'h0A},
    {K_R,4'd10,10'h02D,8'h03}, {K_R,4'd10,10'h02F,8'h01}, {K_R,4'd10,10'h040,8'h00}, // R10
    {K_W,4'd6,10'h123,8'h00}, {K_R,4'd6,10'h010,8'h0C},                 // R6 exit
    {K_W,4'd3,10'h055,8'hAA}, {K_W,4'd3,10'h0AA,8'h55}, {K_W,4'd3,10'h055,8'h80},
    {K_W,4'd3,10'h055,8'hAA}, {K_W,4'd3,10'h0AA,8'h55}, {K_W,4'd3,10'h000,8'h30},
    {K_B,4'd3,10'h000,8'h01},                                           // R3 busy
    {K_W,4'd9,10'h055,8'hAA}, {K_W,4'd9,10'h0AA,8'h55}, {K_W,4'd9,10'h055,8'hA0},
    {K_W,4'd9,10'h120,8'h00}, {K_D,4'd3,10'h000,8'h00}, {K_B,4'd3,10'h000,8'h00},
    {K_R,4'd3,10'h010,8'hFF}, {K_R,4'd9,10'h120,8'hFF}                  // R3 erased, R9 ignored
  };

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [7:0]    wdata = 8'h00;
  logic          wr_en = 1'b0;
  logic          rd_en = 1'b0;
  logic          op_done = 1'b0;
  logic [7:0]    rdata;
  logic          busy;

  int checks = 0;
  int failures = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  nor_cmd_flash u_nor_cmd_flash (
    .clk (clk), .rst_n (rst_n), .addr (addr), .wdata (wdata),
    .wr_en (wr_en), .rd_en (rd_en), .op_done (op_done),
    .rdata (rdata), .busy (busy)
  );

  task automatic wr(input logic [AW-1:0] a, input logic [7:0] d);
    addr = a; wdata = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic chk(input string tag, input logic [7:0] got, input logic [7:0] exp);
    checks++;
    if (got !== exp) begin
      failures++;
      $display("FAIL %s got=%h exp=%h", tag, got, exp);
    end
  endtask

  task automatic rd(input string tag, input logic [AW-1:0] a, input logic [7:0] exp);
    addr = a; rd_en = 1'b1;
    @(negedge clk);
    rd_en = 1'b0;
    chk(tag, rdata, exp);
  endtask

  task automatic done_pulse();
    op_done = 1'b1;
    @(negedge clk);
    op_done = 1'b0;
  endtask

  task automatic unlock();
    wr(10'h055, 8'hAA);
    wr(10'h0AA, 8'h55);
  endtask

  task automatic prog(input logic [AW-1:0] a, input logic [7:0] d);
    unlock();
    wr(10'h055, 8'hA0);
    wr(a, d);
  endtask

  task automatic erase_pre();
    unlock();
    wr(10'h055, 8'h80);
    unlock();
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    @(negedge clk);
    @(negedge clk);
    chk("R11 reset rdata", rdata, 8'h00);
    chk("R11 reset busy", {7'd0, busy}, 8'h00);
    rst_n = 1'b1;
    @(negedge clk);
    rd("R11 erased array", 10'h3FF, 8'hFF);

    for (int i = 0; i < NV; i++) begin
      logic [23:0] e;
      string tg;
      e = VEC[i];
      tg = $sformatf("R%0d vec%0d addr=%h", e[21:18], i, e[17:8]);
      case (e[23:22])
        K_W: wr(e[17:8], e[7:0]);
        K_R: rd(tg, e[17:8], e[7:0]);
        K_D: done_pulse();
        default: chk(tg, {7'd0, busy}, e[7:0]);
      endcase
    end

    // R2 unknown command and wrong command offset
    unlock(); wr(10'h055, 8'h77); wr(10'h055, 8'hA0); wr(10'h040, 8'h00);
    rd("R2 bad command", 10'h040, 8'hFF);
    unlock(); wr(10'h056, 8'hA0); wr(10'h041, 8'h00);
    rd("R2 wrong offset", 10'h041, 8'hFF);
    prog(10'h041, 8'h00);
    rd("R2 good program", 10'h041, 8'h00);

    // R8 bypass programming, bypass erase, exit
    unlock(); wr(10'h055, 8'h20);
    wr(10'h300, 8'hA0); wr(10'h305, 8'h5A);
    rd("R8 bypass prog 1", 10'h305, 8'h5A);
    wr(10'h123, 8'hA0); wr(10'h306, 8'hA5);
    rd("R8 bypass prog 2", 10'h306, 8'hA5);
    wr(10'h3FF, 8'h80); unlock(); wr(10'h3AB, 8'h30);
    chk("R8 bypass erase busy", {7'd0, busy}, 8'h01);
    rd("R8 bypass erase data", 10'h305, 8'hFF);
    done_pulse();
    wr(10'h000, 8'hA0); wr(10'h307, 8'h3C);
    rd("R8 bypass kept after erase", 10'h307, 8'h3C);
    wr(10'h000, 8'h90); wr(10'h000, 8'h00);
    wr(10'h000, 8'hA0); wr(10'h308, 8'h00);
    rd("R8 bypass left", 10'h308, 8'hFF);

    // R3 chip erase offset check, sector isolation, chip erase
    prog(10'h210, 8'h00);
    prog(10'h110, 8'h00);
    erase_pre(); wr(10'h056, 8'h10);
    chk("R3 chip erase bad offset busy", {7'd0, busy}, 8'h00);
    rd("R3 chip erase bad offset data", 10'h210, 8'h00);
    erase_pre(); wr(10'h1AB, 8'h30);
    rd("R3 sector erased", 10'h110, 8'hFF);
    rd("R3 other sector kept", 10'h210, 8'h00);
    done_pulse();
    erase_pre(); wr(10'h055, 8'h10);
    chk("R3 chip erase busy", {7'd0, busy}, 8'h01);
    rd("R3 chip erase s2", 10'h210, 8'hFF);
    rd("R3 chip erase s3", 10'h307, 8'hFF);
    rd("R3 chip erase s0", 10'h041, 8'hFF);
    done_pulse();
    chk("R3 busy released", {7'd0, busy}, 8'h00);

    // R6 query entry from read mode; R11 hold
    wr(10'h055, 8'h98);
    rd("R10 query byte 0x11", 10'h011, 8'h52);
    repeat (3) @(negedge clk);
    chk("R11 rdata hold", rdata, 8'h52);
    rd("R10 query byte 0x13", 10'h013, 8'h02);
    wr(10'h000, 8'h00);
    rd("R6 left query", 10'h011, 8'hFF);

    // R11 reset in the middle of a sequence
    unlock(); wr(10'h055, 8'hA0);
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    wr(10'h040, 8'h00);
    rd("R11 sequence restarted", 10'h040, 8'hFF);

    finish_run();
  end

endmodule